// File: doc/BRIEF.md
# Matched TLB Entry Permission and Address Translator

This block takes one translation entry that an earlier search has already found to match, and turns it into a physical address with read, write and execute permissions, or into a fault code. An entry holds two page halves, even and odd. A bit of the virtual address picks between them, and that bit's position is the page size. The page size comes from the entry itself or from a global setting, depending on which TLB array holds the entry. The selected half then goes through a fixed order of checks: validity, execute inhibit, read inhibit, privilege and dirty state.

The block gives its results two ways. A combinational copy settles in the same cycle as the inputs. A registered copy sits behind a one-deep valid/ready stage. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the registered result holds still and new requests wait. Searching for the entry, refilling the TLB and raising exceptions are handled elsewhere.

Top module: `tlbx_translate`

## Requirements
- R1: The effective page size PS is `entry_ps` when `from_mtlb` is 1 and `stlb_ps` when it is 0. The chosen value is then clamped to the range 12..30.
- R2: Virtual address bit [PS] picks the half. A 1 selects `odd_half` and a 0 selects `even_half`. Within a half, bit 0 is valid, bit 1 is dirty, bits [3:2] are the page level, bit 60 is no-read, bit 61 is no-execute, bit 62 is restricted-privilege and bits [PA_W-1:12] are the page number.
- R3: When `mode64` is 0, the no-read, no-execute and restricted-privilege bits of the selected half are treated as 0.
- R4: `res_code` reports the first fault that applies, in this order: not valid (1), a fetch (`access`=0) to a no-execute page (2), a load (`access`=1) from a no-read page (3), a privilege violation (4), and a store (`access`=2) to a page that is not dirty (5). If no fault applies the code is 0. An `access` value of 3 is subject only to the validity and privilege checks.
- R5: With restricted-privilege 0, a privilege violation is `cur_plv` greater than the page level. With restricted-privilege 1, a privilege violation is any difference between `cur_plv` and the page level.
- R6: On a match, `pa` takes virtual address bits below PS and page-number bits from PS upward. Page-number bits 12..PS-1 are discarded.
- R7: `perm` bits are [0] read, [1] write and [2] execute. On a match, read is 1, write equals the dirty bit and execute is the inverse of no-execute. On any fault, `perm` and `pa` are all zero.
- R8: A request accepted on a clock edge appears on `out_pa`, `out_perm` and `out_code` with `out_valid` after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the registered outputs do not change.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| even_half | input | 64 | Even page half of the entry |
| odd_half | input | 64 | Odd page half of the entry |
| entry_ps | input | 5 | Entry's own page size |
| stlb_ps | input | 5 | Global page size of the small array |
| from_mtlb | input | 1 | 1 if the entry is from the multi-size array |
| va | input | VA_W | Virtual address |
| access | input | 2 | 0 fetch, 1 load, 2 store, 3 other |
| cur_plv | input | 2 | Current privilege level |
| mode64 | input | 1 | 1 for 64-bit mode |
| pa | output | PA_W | Combinational physical address |
| perm | output | 3 | Combinational permissions {x,w,r} |
| res_code | output | 3 | Combinational result code |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the registered result |
| out_pa | output | PA_W | Registered physical address |
| out_perm | output | 3 | Registered permissions |
| out_code | output | 3 | Registered result code |

## Verification
Several fault conditions can be true in the same cycle. Only the earliest in the order may win. The bench builds halves that trigger invalid, execute inhibit, read inhibit, privilege and dirty faults together, then removes one cause at a time and expects the code to step down the list. A second overlap is a new request arriving while the output register is stalled. The bench holds `out_ready` low, offers a second request and checks that `in_ready` is low and that the held result has not changed. It then checks that the waiting request appears once the stage drains.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_XINH    = 3'd2,
    RES_RINH    = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

  localparam int HALF_W  = 64;
  localparam int PSW     = 5;
  localparam int BIT_VAL = 0;
  localparam int BIT_DRT = 1;
  localparam int PLV_LO  = 2;
  localparam int BIT_NR  = 60;
  localparam int BIT_NX  = 61;
  localparam int BIT_RP  = 62;
  localparam int PS_MIN  = 12;
  localparam int PS_MAX  = 30;

  typedef struct packed {
    logic       valid;
    logic       dirty;
    logic [1:0] level;
    logic       no_rd;
    logic       no_ex;
    logic       strict;
  } attr_t;
endpackage

// File: rtl/tlbx_half_sel.sv
module tlbx_half_sel
  import tlbx_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic [PSW-1:0]    entry_ps,
  input  logic [PSW-1:0]    stlb_ps,
  input  logic              from_mtlb,
  input  logic [VA_W-1:0]   va,
  input  logic [HALF_W-1:0] even_half,
  input  logic [HALF_W-1:0] odd_half,
  output logic [PSW-1:0]    ps_eff,
  output logic [HALF_W-1:0] half
);
  logic [PSW-1:0] ps_raw;

  always_comb begin
    ps_raw = from_mtlb ? entry_ps : stlb_ps;
    if (ps_raw < PSW'(PS_MIN))      ps_eff = PSW'(PS_MIN);
    else if (ps_raw > PSW'(PS_MAX)) ps_eff = PSW'(PS_MAX);
    else                            ps_eff = ps_raw;
    half = va[ps_eff] ? odd_half : even_half;
  end
endmodule

// File: rtl/tlbx_attr_dec.sv
module tlbx_attr_dec
  import tlbx_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [HALF_W-1:0] half,
  input  logic              mode64,
  output attr_t             attr
);
  logic ext_en;

  generate
    if (HAS_EXT) begin : g_ext
      assign ext_en = mode64;
    end else begin : g_noext
      assign ext_en = 1'b0;
    end
  endgenerate

  always_comb begin
    attr.valid  = half[BIT_VAL];
    attr.dirty  = half[BIT_DRT];
    attr.level  = half[PLV_LO+1:PLV_LO];
    attr.no_rd  = ext_en & half[BIT_NR];
    attr.no_ex  = ext_en & half[BIT_NX];
    attr.strict = ext_en & half[BIT_RP];
  end
endmodule

// File: rtl/tlbx_fault_chk.sv
module tlbx_fault_chk
  import tlbx_pkg::*;
(
  input  attr_t      attr,
  input  logic [1:0] access,
  input  logic [1:0] cur_plv,
  output res_e       code,
  output logic       priv_bad
);
  always_comb begin
    priv_bad = attr.strict ? (cur_plv != attr.level) : (cur_plv > attr.level);
    if (!attr.valid)                                 code = RES_INVALID;
    else if (access == ACC_FETCH && attr.no_ex)      code = RES_XINH;
    else if (access == ACC_LOAD && attr.no_rd)       code = RES_RINH;
    else if (priv_bad)                               code = RES_PRIV;
    else if (access == ACC_STORE && !attr.dirty)     code = RES_DIRTY;
    else                                             code = RES_MATCH;
  end
endmodule

// File: rtl/tlbx_addr_form.sv
module tlbx_addr_form
  import tlbx_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic [HALF_W-1:0] half,
  input  logic [VA_W-1:0]   va,
  input  logic [PSW-1:0]    ps,
  output logic [PA_W-1:0]   pa
);
  logic [PA_W-1:0] keep_va;
  logic [PA_W-1:0] va_ext;

  assign keep_va = ~({PA_W{1'b1}} << ps);

  generate
    if (VA_W >= PA_W) begin : g_va_wide
      assign va_ext = va[PA_W-1:0];
    end else begin : g_va_narrow
      assign va_ext = {{(PA_W-VA_W){1'b0}}, va};
    end
    for (genvar i = 0; i < PA_W; i++) begin : g_bit
      if (i < PS_MIN) begin : g_ofs
        assign pa[i] = va_ext[i];
      end else begin : g_pg
        assign pa[i] = keep_va[i] ? va_ext[i] : half[i];
      end
    end
  endgenerate
endmodule

// File: rtl/tlbx_translate.sv
module tlbx_translate
  import tlbx_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       even_half,
  input  logic [63:0]       odd_half,
  input  logic [4:0]        entry_ps,
  input  logic [4:0]        stlb_ps,
  input  logic              from_mtlb,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        access,
  input  logic [1:0]        cur_plv,
  input  logic              mode64,
  output logic [PA_W-1:0]   pa,
  output logic [2:0]        perm,
  output logic [2:0]        res_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_pa,
  output logic [2:0]        out_perm,
  output logic [2:0]        out_code
);
  logic [PSW-1:0]    ps_eff;
  logic [HALF_W-1:0] half;
  attr_t             attr;
  res_e              code;
  logic              priv_bad;
  logic [PA_W-1:0]   pa_raw;
  logic              is_match;
  logic              take;

  tlbx_half_sel #(.VA_W(VA_W)) u_sel (
    .entry_ps(entry_ps), .stlb_ps(stlb_ps), .from_mtlb(from_mtlb), .va(va),
    .even_half(even_half), .odd_half(odd_half), .ps_eff(ps_eff), .half(half)
  );

  tlbx_attr_dec #(.HAS_EXT(1'b1)) u_dec (
    .half(half), .mode64(mode64), .attr(attr)
  );

  tlbx_fault_chk u_chk (
    .attr(attr), .access(access), .cur_plv(cur_plv), .code(code), .priv_bad(priv_bad)
  );

  tlbx_addr_form #(.VA_W(VA_W), .PA_W(PA_W)) u_addr (
    .half(half), .va(va), .ps(ps_eff), .pa(pa_raw)
  );

  assign is_match = (code == RES_MATCH);
  assign res_code = code;
  assign pa       = is_match ? pa_raw : '0;
  assign perm     = is_match ? {~attr.no_ex, attr.dirty, 1'b1} : 3'b000;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_perm  <= '0;
      out_code  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_pa    <= pa;
        out_perm  <= perm;
        out_code  <= res_code;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !half[BIT_VAL] |-> res_code == 3'd1) else $error("invalid not first"); // R4
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    res_code != 3'd0 |-> perm == 3'b000 && pa == '0) else $error("perm on fault"); // R7
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_code == 3'd0 |-> perm[1] == half[BIT_DRT] && perm[0]) else $error("write perm"); // R7
  AST_NARROW_NO_INH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode64 |-> res_code != 3'd2 && res_code != 3'd3) else $error("inhibit in 32-bit"); // R3
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_code == 3'd0 |-> pa[11:0] == va[11:0]) else $error("offset"); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pa) && $stable(out_code)
    && $stable(out_perm)) else $error("held output moved"); // R8
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) else $error("accept lost"); // R8
endmodule

// File: tb/test_tlbx_translate.sv
module test_tlbx_translate;
  localparam int VA_W = 48;
  localparam int PA_W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [63:0] even_half = '0, odd_half = '0;
  logic [4:0] entry_ps = 5'd12, stlb_ps = 5'd12;
  logic from_mtlb = 1'b0;
  logic [VA_W-1:0] va = '0;
  logic [1:0] access = 2'd1, cur_plv = 2'd0;
  logic mode64 = 1'b1;
  logic [PA_W-1:0] pa, out_pa;
  logic [2:0] perm, res_code, out_perm, out_code;
  logic out_valid, out_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tlbx_translate #(.VA_W(VA_W), .PA_W(PA_W)) i_tlbx_translate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .even_half(even_half), .odd_half(odd_half), .entry_ps(entry_ps), .stlb_ps(stlb_ps),
    .from_mtlb(from_mtlb), .va(va), .access(access), .cur_plv(cur_plv), .mode64(mode64),
    .pa(pa), .perm(perm), .res_code(res_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_pa(out_pa), .out_perm(out_perm), .out_code(out_code)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit v, bit d, logic [1:0] lvl, bit nr, bit nx,
                                     bit rp, logic [35:0] pn);
    logic [63:0] h = '0;
    h[0] = v; h[1] = d; h[3:2] = lvl; h[60] = nr; h[61] = nx; h[62] = rp;
    h[47:12] = pn;
    return h;
  endfunction

  task automatic drive(logic [63:0] e, logic [63:0] o, logic [4:0] eps, logic [4:0] sps,
                       bit fm, logic [47:0] a, logic [1:0] acc, logic [1:0] pl, bit m64);
    @(negedge clk);
    even_half = e; odd_half = o; entry_ps = eps; stlb_ps = sps; from_mtlb = fm;
    va = a; access = acc; cur_plv = pl; mode64 = m64;
    #1;
  endtask

  task automatic t_reset();
    chk("R9 out_valid", out_valid, 0);
    chk("R9 in_ready", in_ready, 1);
  endtask

  task automatic t_ps_select();
    // even invalid, odd valid: code tells which half was chosen
    drive(mk(0,1,0,0,0,0,0), mk(1,1,0,0,0,0,0), 5'd14, 5'd12, 1, 48'h4000, 1, 0, 1);
    chk("R1 R2 mtlb ps14 odd", res_code, 0);
    drive(mk(0,1,0,0,0,0,0), mk(1,1,0,0,0,0,0), 5'd14, 5'd12, 0, 48'h4000, 1, 0, 1);
    chk("R1 R2 stlb ps12 even", res_code, 1);
    drive(mk(0,1,0,0,0,0,0), mk(1,1,0,0,0,0,0), 5'd31, 5'd12, 1, 48'h4000_0000, 1, 0, 1);
    chk("R1 clamp high to 30", res_code, 0);
    drive(mk(1,1,0,0,0,0,0), mk(0,1,0,0,0,0,0), 5'd3, 5'd12, 1, 48'h2000, 1, 0, 1);
    chk("R1 clamp low to 12", res_code, 0);
  endtask

  task automatic t_priority();
    drive(mk(0,0,0,1,1,0,0), 0, 12, 12, 0, 0, 0, 3, 1);
    chk("R4 invalid first", res_code, 1);
    drive(mk(1,0,0,1,1,0,0), 0, 12, 12, 0, 0, 0, 3, 1);
    chk("R4 exec inhibit", res_code, 2);
    drive(mk(1,0,0,1,1,0,0), 0, 12, 12, 0, 0, 1, 3, 1);
    chk("R4 read inhibit", res_code, 3);
    drive(mk(1,0,0,1,1,0,0), 0, 12, 12, 0, 0, 2, 3, 1);
    chk("R4 privilege before dirty", res_code, 4);
    drive(mk(1,0,3,1,1,0,0), 0, 12, 12, 0, 0, 2, 3, 1);
    chk("R4 dirty fault", res_code, 5);
    drive(mk(1,0,3,1,1,0,0), 0, 12, 12, 0, 0, 3, 3, 1);
    chk("R4 other access match", res_code, 0);
  endtask

  task automatic t_priv();
    drive(mk(1,1,2,0,0,0,0), 0, 12, 12, 0, 0, 1, 3, 1);
    chk("R5 plain greater", res_code, 4);
    drive(mk(1,1,2,0,0,0,0), 0, 12, 12, 0, 0, 1, 1, 1);
    chk("R5 plain lower ok", res_code, 0);
    drive(mk(1,1,2,0,0,1,0), 0, 12, 12, 0, 0, 1, 1, 1);
    chk("R5 strict lower", res_code, 4);
    drive(mk(1,1,2,0,0,1,0), 0, 12, 12, 0, 0, 1, 2, 1);
    chk("R5 strict equal ok", res_code, 0);
  endtask

  task automatic t_mode32();
    drive(mk(1,1,2,1,1,1,0), 0, 12, 12, 0, 0, 0, 1, 0);
    chk("R3 32-bit fetch code", res_code, 0);
    chk("R3 32-bit exec perm", perm, 3'b111);
    drive(mk(1,1,2,1,1,1,0), 0, 12, 12, 0, 0, 1, 1, 0);
    chk("R3 32-bit load code", res_code, 0);
  endtask

  task automatic t_addr();
    drive(mk(1,1,0,0,0,0,36'hABCDE_F123), 0, 16, 12, 1, 48'h1234_5678_2ABC, 1, 0, 1);
    chk("R6 ps16", pa, 48'hABCD_EF12_2ABC);
    drive(mk(1,1,0,0,0,0,36'h1_2345_6789), mk(1,1,0,0,0,0,36'hF_FFFF_FFFF), 12, 12, 0,
          48'h0000_0000_0FED, 1, 0, 1);
    chk("R6 ps12 even", pa, 48'h1234_5678_9FED);
  endtask

  task automatic t_perm();
    drive(mk(1,0,0,0,1,0,0), 0, 12, 12, 0, 0, 1, 0, 1);
    chk("R7 read-only no exec", perm, 3'b001);
    drive(mk(1,1,0,0,0,0,36'h5), 0, 12, 12, 0, 48'h123, 2, 0, 1);
    chk("R7 full perms", perm, 3'b111);
    drive(mk(1,0,0,0,0,0,36'h5), 0, 12, 12, 0, 48'h123, 2, 0, 1);
    chk("R7 fault perms", perm, 0);
    chk("R7 fault pa", pa, 0);
  endtask

  task automatic t_stream();
    drive(mk(1,1,0,0,0,0,36'h77), 0, 12, 12, 0, 48'h11, 1, 0, 1);
    out_ready = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 first captured valid", out_valid, 1);
    chk("R8 first pa", out_pa, 48'h77011);
    chk("R8 first perm", out_perm, 3'b111);
    chk("R8 stall in_ready", in_ready, 0);
    va = 48'h22; access = 2'd2; even_half = mk(1,0,0,0,0,0,36'h99);
    @(negedge clk);
    chk("R8 held pa", out_pa, 48'h77011);
    chk("R8 held code", out_code, 0);
    out_ready = 1'b1; #1;
    chk("R8 ready when draining", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second code", out_code, 5);
    chk("R8 second pa", out_pa, 0);
    @(negedge clk);
    chk("R8 drained", out_valid, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_ps_select();
    t_priority();
    t_priv();
    t_mode32();
    t_addr();
    t_perm();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule